// File: doc/BRIEF.md
# SCSI Initiator Register and Interrupt Interface

This block is the byte-wide register file of a SCSI initiator controller. A host reaches it over a simple register bus: an 8-bit offset, 8-bit write and read data, and one strobe each for write and read. The block holds the 16-bit transfer count, the FIFO count, the last command byte, the source and destination IDs, the synchronous transfer parameters, the interrupt mask and the interrupt status. It also returns a fixed chip identification byte.

When the host writes the command register, the block sends a one-cycle start pulse and the opcode to the sequencer. The sequencer reports completion and exceptions back through two event inputs, and these set interrupt status bits. A write to the upper bus-control byte drives the SCSI control lines directly. The block emits an assert or release pulse only for the lines whose value has changed. A single registered level interrupt combines the status bits with the mask. The asynchronous reset `rst_ni` is the hard reset. `soft_rst_i` is a lighter synchronous reset that keeps the line-drive state and the sync parameters.

Top module: `scsi_init_regs`

## Requirements
- R1: The transfer count, loaded through `xcnt_we_i`/`xcnt_i`, reads low byte at offset 0x00 and high byte at 0x01; the FIFO count, loaded through `fcnt_we_i`/`fcnt_i`, reads at 0x02.
- R2: Reading the command register (0x03) returns the last byte written there.
- R3: A write to 0x03 produces `cmd_start_o`=1 with `cmd_op_o` equal to the written byte in the next cycle only, and clears status bit 0 (command done) unless `seq_done_i` is high in the same cycle.
- R4: Status (0x04) bit 0 is set by `seq_done_i`, bit 1 by `seq_exc_i`; writing 0x04 clears each of bits 1:0 written as 1, bits 7:2 always read 0, and a set event wins over a clear in the same cycle.
- R5: `irq_o` equals the OR of status AND mask (mask at 0x05), one clock after the status or mask changes.
- R6: Hard and soft reset both set the command to 0x00, the FIFO count, mask and transfer count to 0, and the source ID (0x0A) to 7.
- R7: Only hard reset clears the held line-drive byte and sets sync parameters (0x0C) to 0x02; soft reset keeps them, and the destination ID (0x0B).
- R8: A write to 0x09 stores the byte on `ctl_drive_o` and, one cycle later for one cycle, pulses `ctl_assert_o` for bits 5:0 that went 0 to 1 and `ctl_release_o` for bits 5:0 that went 1 to 0; bits 7:6 never pulse.
- R9: Reading 0x08 returns `scsi_ctl_i[7:0]`; reading 0x09 returns `scsi_ctl_i[15:13]` in bits 7:5, zero below.
- R10: Offsets 0x06 (exception) and 0x07 (error) read 0; 0x0D returns the parameter `CHIP_ID` (default 0x4E).
- R11: Reads of offsets above 0x0D, or with `reg_rd_i` low, return 0; writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, combinational |
| xcnt_we_i | input | 1 | Load transfer count |
| xcnt_i | input | 16 | Transfer count value |
| fcnt_we_i | input | 1 | Load FIFO count |
| fcnt_i | input | 8 | FIFO count value |
| scsi_ctl_i | input | 16 | Sampled SCSI control lines |
| ctl_drive_o | output | 8 | Held upper control byte |
| ctl_assert_o | output | 8 | Per-line assert pulse |
| ctl_release_o | output | 8 | Per-line release pulse |
| cmd_start_o | output | 1 | Command start pulse |
| cmd_op_o | output | 8 | Current command byte |
| src_id_o | output | 8 | Source ID |
| dst_id_o | output | 8 | Destination ID |
| sync_par_o | output | 8 | Sync parameters |
| seq_done_i | input | 1 | Sequencer command-done event |
| seq_exc_i | input | 1 | Sequencer exception event |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational. The bench samples it 1 ns after it changes offset, with the read strobe held in the same half cycle. A write or event takes effect at the next rising edge, so the stored value, `ctl_drive_o`, the line pulses and `cmd_start_o` are checked at the falling edge that follows. `irq_o` lags the status and mask by one more edge. The bench checks it low at the first falling edge after the change and at its new value at the second.

// File: rtl/scsi_ir_pkg.sv
package scsi_ir_pkg;
  localparam int DW    = 8;
  localparam int INT_W = 2;
  localparam logic [DW-1:0] LINE_MASK = 8'h3F;
  localparam logic [DW-1:0] CMD_NOP   = 8'h00;
  localparam logic [DW-1:0] SRC_RST   = 8'h07;
  localparam logic [DW-1:0] SYNC_RST  = 8'h02;

  typedef enum logic [7:0] {
    OFF_XLO  = 8'h00,
    OFF_XHI  = 8'h01,
    OFF_FCNT = 8'h02,
    OFF_CMD  = 8'h03,
    OFF_STAT = 8'h04,
    OFF_MASK = 8'h05,
    OFF_EXC  = 8'h06,
    OFF_ERR  = 8'h07,
    OFF_BLO  = 8'h08,
    OFF_BHI  = 8'h09,
    OFF_SRC  = 8'h0A,
    OFF_DST  = 8'h0B,
    OFF_SYNC = 8'h0C,
    OFF_ID   = 8'h0D
  } reg_off_e;
endpackage

// File: rtl/scsi_ir_cfg.sv
module scsi_ir_cfg
  import scsi_ir_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wr_cmd_i,
  input  logic          wr_mask_i,
  input  logic          wr_src_i,
  input  logic          wr_dst_i,
  input  logic          wr_sync_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xcnt_we_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic          fcnt_we_i,
  input  logic [DW-1:0] fcnt_i,
  output logic [CW-1:0] xcnt_o,
  output logic [DW-1:0] fcnt_o,
  output logic [DW-1:0] cmd_o,
  output logic          start_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] sync_o
);
  // registers cleared by either reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcnt_o <= '0;
      fcnt_o <= '0;
      cmd_o  <= CMD_NOP;
      mask_o <= '0;
      src_o  <= SRC_RST;
    end else if (soft_rst_i) begin
      xcnt_o <= '0;
      fcnt_o <= '0;
      cmd_o  <= CMD_NOP;
      mask_o <= '0;
      src_o  <= SRC_RST;
    end else begin
      if (xcnt_we_i) xcnt_o <= xcnt_i;
      if (fcnt_we_i) fcnt_o <= fcnt_i;
      if (wr_cmd_i)  cmd_o  <= wdata_i;
      if (wr_mask_i) mask_o <= wdata_i;
      if (wr_src_i)  src_o  <= wdata_i;
    end
  end

  // registers only the hard reset touches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o   <= '0;
      sync_o  <= SYNC_RST;
      start_o <= 1'b0;
    end else begin
      start_o <= wr_cmd_i & ~soft_rst_i;
      if (wr_dst_i)  dst_o  <= wdata_i;
      if (wr_sync_i) sync_o <= wdata_i;
    end
  end
endmodule

// File: rtl/scsi_ir_busctl.sv
module scsi_ir_busctl
  import scsi_ir_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] drive_o,
  output logic [DW-1:0] assert_o,
  output logic [DW-1:0] release_o
);
  logic [DW-1:0] diff;
  assign diff = (wdata_i ^ drive_o) & LINE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o   <= '0;
      assert_o  <= '0;
      release_o <= '0;
    end else begin
      assert_o  <= '0;
      release_o <= '0;
      if (wr_i) begin
        drive_o   <= wdata_i;
        assert_o  <= diff & wdata_i;
        release_o <= diff & ~wdata_i;
      end
    end
  end
endmodule

// File: rtl/scsi_ir_irq.sv
module scsi_ir_irq
  import scsi_ir_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stat_i,
  input  logic             wr_cmd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             done_i,
  input  logic             exc_i,
  input  logic [DW-1:0]    mask_i,
  output logic [INT_W-1:0] stat_o,
  output logic             irq_o
);
  logic [INT_W-1:0] clr, set;

  always_comb begin
    clr = '0;
    if (wr_stat_i) clr = wdata_i[INT_W-1:0];
    if (wr_cmd_i)  clr[0] = 1'b1;
    set = {exc_i, done_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= (stat_o & ~clr) | set;
      irq_o  <= |(stat_o & mask_i[INT_W-1:0]);
    end
  end
endmodule

// File: rtl/scsi_init_regs.sv
module scsi_init_regs
  import scsi_ir_pkg::*;
#(
  parameter int          CW      = 16,
  parameter logic [7:0]  CHIP_ID = 8'h4E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          xcnt_we_i,
  input  logic [CW-1:0] xcnt_i,
  input  logic          fcnt_we_i,
  input  logic [7:0]    fcnt_i,
  input  logic [15:0]   scsi_ctl_i,
  output logic [7:0]    ctl_drive_o,
  output logic [7:0]    ctl_assert_o,
  output logic [7:0]    ctl_release_o,
  output logic          cmd_start_o,
  output logic [7:0]    cmd_op_o,
  output logic [7:0]    src_id_o,
  output logic [7:0]    dst_id_o,
  output logic [7:0]    sync_par_o,
  input  logic          seq_done_i,
  input  logic          seq_exc_i,
  output logic          irq_o
);
  logic wr_cmd, wr_stat, wr_mask, wr_bhi, wr_src, wr_dst, wr_sync;
  assign wr_cmd  = reg_wr_i && reg_addr_i == OFF_CMD;
  assign wr_stat = reg_wr_i && reg_addr_i == OFF_STAT;
  assign wr_mask = reg_wr_i && reg_addr_i == OFF_MASK;
  assign wr_bhi  = reg_wr_i && reg_addr_i == OFF_BHI;
  assign wr_src  = reg_wr_i && reg_addr_i == OFF_SRC;
  assign wr_dst  = reg_wr_i && reg_addr_i == OFF_DST;
  assign wr_sync = reg_wr_i && reg_addr_i == OFF_SYNC;

  logic [CW-1:0]    xcnt_q;
  logic [DW-1:0]    fcnt_q, int_mask_q;
  logic [INT_W-1:0] int_stat_q;

  scsi_ir_cfg #(.CW(CW)) u_cfg (
    .clk_i, .rst_ni, .soft_rst_i,
    .wr_cmd_i(wr_cmd), .wr_mask_i(wr_mask), .wr_src_i(wr_src),
    .wr_dst_i(wr_dst), .wr_sync_i(wr_sync), .wdata_i(reg_wdata_i),
    .xcnt_we_i, .xcnt_i, .fcnt_we_i, .fcnt_i,
    .xcnt_o(xcnt_q), .fcnt_o(fcnt_q), .cmd_o(cmd_op_o), .start_o(cmd_start_o),
    .mask_o(int_mask_q), .src_o(src_id_o), .dst_o(dst_id_o), .sync_o(sync_par_o)
  );

  scsi_ir_busctl u_bus (
    .clk_i, .rst_ni, .wr_i(wr_bhi), .wdata_i(reg_wdata_i),
    .drive_o(ctl_drive_o), .assert_o(ctl_assert_o), .release_o(ctl_release_o)
  );

  scsi_ir_irq u_irq (
    .clk_i, .rst_ni, .wr_stat_i(wr_stat), .wr_cmd_i(wr_cmd), .wdata_i(reg_wdata_i),
    .done_i(seq_done_i), .exc_i(seq_exc_i), .mask_i(int_mask_q),
    .stat_o(int_stat_q), .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        OFF_XLO:  reg_rdata_o = xcnt_q[7:0];
        OFF_XHI:  reg_rdata_o = xcnt_q[15:8];
        OFF_FCNT: reg_rdata_o = fcnt_q;
        OFF_CMD:  reg_rdata_o = cmd_op_o;
        OFF_STAT: reg_rdata_o = {{(DW-INT_W){1'b0}}, int_stat_q};
        OFF_MASK: reg_rdata_o = int_mask_q;
        OFF_BLO:  reg_rdata_o = scsi_ctl_i[7:0];
        OFF_BHI:  reg_rdata_o = {scsi_ctl_i[15:13], 5'b0};
        OFF_SRC:  reg_rdata_o = src_id_o;
        OFF_DST:  reg_rdata_o = dst_id_o;
        OFF_SYNC: reg_rdata_o = sync_par_o;
        OFF_ID:   reg_rdata_o = CHIP_ID;
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/scsi_init_regs_chk.sv
module scsi_init_regs_chk
  import scsi_ir_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [7:0]       reg_rdata_o,
  input logic [7:0]       ctl_assert_o,
  input logic [7:0]       ctl_release_o,
  input logic             cmd_start_o,
  input logic [7:0]       cmd_op_o,
  input logic             seq_done_i,
  input logic             soft_rst_i,
  input logic [INT_W-1:0] int_stat_q,
  input logic [7:0]       int_mask_q,
  input logic             irq_o
);
  // R3
  cmd_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFF_CMD && !soft_rst_i) |=> (cmd_start_o && cmd_op_o == $past(reg_wdata_i)));
  // R3
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == OFF_CMD) |=> !cmd_start_o);
  // R3
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFF_CMD && !seq_done_i) |=> !int_stat_q[0]);
  // R4
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_i |=> int_stat_q[0]);
  // R5
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(int_stat_q & int_mask_q[INT_W-1:0])));
  // R8
  line_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_assert_o & ctl_release_o) == '0) && (((ctl_assert_o | ctl_release_o) & ~LINE_MASK) == '0));
  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rd_i || reg_addr_i > OFF_ID) |-> reg_rdata_o == '0);
endmodule

bind scsi_init_regs scsi_init_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
  .ctl_assert_o(ctl_assert_o), .ctl_release_o(ctl_release_o),
  .cmd_start_o(cmd_start_o), .cmd_op_o(cmd_op_o), .seq_done_i(seq_done_i),
  .soft_rst_i(soft_rst_i), .int_stat_q(int_stat_q), .int_mask_q(int_mask_q), .irq_o(irq_o)
);

// File: tb/scsi_init_regs_tb.sv
module scsi_init_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0;
  logic xwe = 1'b0, fwe = 1'b0;
  logic [15:0] xcnt = '0, sctl = '0;
  logic [7:0] fcnt = '0;
  logic [7:0] drv, asrt, rel, op, src, dst, syn;
  logic start, done = 1'b0, exc = 1'b0, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  scsi_init_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd), .reg_rdata_o(rdata),
    .xcnt_we_i(xwe), .xcnt_i(xcnt), .fcnt_we_i(fwe), .fcnt_i(fcnt), .scsi_ctl_i(sctl),
    .ctl_drive_o(drv), .ctl_assert_o(asrt), .ctl_release_o(rel),
    .cmd_start_o(start), .cmd_op_o(op), .src_id_o(src), .dst_id_o(dst), .sync_par_o(syn),
    .seq_done_i(done), .seq_exc_i(exc), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rd = 1'b1; #1;
    chk(req, {8'h0, rdata}, {8'h0, exp});
    rd = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R6 cmd", 8'h03, 8'h00);
    rd_chk("R6 src", 8'h0A, 8'h07);
    rd_chk("R6 mask", 8'h05, 8'h00);
    rd_chk("R6 xlo", 8'h00, 8'h00);
    rd_chk("R7 sync", 8'h0C, 8'h02);
    chk("R7 drive", {8'h0, drv}, 16'h0);
    chk("R5 irq", {15'h0, irq}, 16'h0);
    rd_chk("R10 id", 8'h0D, 8'h4E);
  endtask

  task automatic t_counts;
    @(negedge clk); xcnt = 16'hA5C3; xwe = 1'b1; fcnt = 8'h17; fwe = 1'b1;
    @(negedge clk); xwe = 1'b0; fwe = 1'b0;
    rd_chk("R1 xlo", 8'h00, 8'hC3);
    rd_chk("R1 xhi", 8'h01, 8'hA5);
    rd_chk("R1 fcnt", 8'h02, 8'h17);
  endtask

  task automatic t_cmd;
    wr_reg(8'h03, 8'h21);
    chk("R3 start", {15'h0, start}, 16'h1);
    chk("R3 op", {8'h0, op}, 16'h0021);
    @(negedge clk);
    chk("R3 start drop", {15'h0, start}, 16'h0);
    rd_chk("R2 cmd read", 8'h03, 8'h21);
  endtask

  task automatic t_irq;
    @(negedge clk); done = 1'b1; exc = 1'b1;
    @(negedge clk); done = 1'b0; exc = 1'b0;
    rd_chk("R4 stat", 8'h04, 8'h03);
    chk("R5 masked", {15'h0, irq}, 16'h0);
    wr_reg(8'h05, 8'h01);
    chk("R5 lag", {15'h0, irq}, 16'h0);
    @(negedge clk);
    chk("R5 irq up", {15'h0, irq}, 16'h1);
    wr_reg(8'h04, 8'hFE);
    rd_chk("R4 w1c field", 8'h04, 8'h01);
    // clear with simultaneous set: set wins
    @(negedge clk); addr = 8'h04; wdata = 8'h01; wr = 1'b1; done = 1'b1;
    @(negedge clk); wr = 1'b0; done = 1'b0;
    rd_chk("R4 set wins", 8'h04, 8'h01);
    wr_reg(8'h03, 8'h02);
    rd_chk("R3 done cleared", 8'h04, 8'h00);
    @(negedge clk);
    chk("R5 irq down", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_bus;
    wr_reg(8'h09, 8'h05);
    chk("R8 assert1", {8'h0, asrt}, 16'h05);
    chk("R8 release1", {8'h0, rel}, 16'h00);
    chk("R8 drive1", {8'h0, drv}, 16'h05);
    wr_reg(8'h09, 8'h0C);
    chk("R8 assert2", {8'h0, asrt}, 16'h08);
    chk("R8 release2", {8'h0, rel}, 16'h01);
    wr_reg(8'h09, 8'hC0);
    chk("R8 assert3", {8'h0, asrt}, 16'h00);
    chk("R8 release3", {8'h0, rel}, 16'h0C);
    chk("R8 drive3", {8'h0, drv}, 16'hC0);
    @(negedge clk);
    chk("R8 pulse end", {8'h0, asrt | rel}, 16'h0);
    sctl = 16'hE0A5;
    rd_chk("R9 lo", 8'h08, 8'hA5);
    rd_chk("R9 hi", 8'h09, 8'hE0);
    sctl = 16'h5F00;
    rd_chk("R9 hi2", 8'h09, 8'h40);
  endtask

  task automatic t_misc;
    rd_chk("R10 exc", 8'h06, 8'h00);
    rd_chk("R10 err", 8'h07, 8'h00);
    wr_reg(8'h0A, 8'h03);
    wr_reg(8'h40, 8'hFF);
    wr_reg(8'h0E, 8'hFF);
    rd_chk("R11 unmapped", 8'h40, 8'h00);
    rd_chk("R11 src kept", 8'h0A, 8'h03);
    rd_chk("R11 sync kept", 8'h0C, 8'h02);
    rd_chk("R11 mask kept", 8'h05, 8'h01);
    @(negedge clk); addr = 8'h0A; rd = 1'b0; #1;
    chk("R11 no strobe", {8'h0, rdata}, 16'h0);
  endtask

  task automatic t_soft;
    wr_reg(8'h0C, 8'h11);
    wr_reg(8'h0B, 8'h05);
    wr_reg(8'h09, 8'h05);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd_chk("R6 soft cmd", 8'h03, 8'h00);
    rd_chk("R6 soft src", 8'h0A, 8'h07);
    rd_chk("R6 soft mask", 8'h05, 8'h00);
    rd_chk("R6 soft xhi", 8'h01, 8'h00);
    rd_chk("R6 soft fcnt", 8'h02, 8'h00);
    rd_chk("R7 soft sync", 8'h0C, 8'h11);
    rd_chk("R7 soft dst", 8'h0B, 8'h05);
    chk("R7 soft drive", {8'h0, drv}, 16'h05);
  endtask

  task automatic t_hard;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R7 hard sync", 8'h0C, 8'h02);
    chk("R7 hard drive", {8'h0, drv}, 16'h00);
    rd_chk("R6 hard src", 8'h0A, 8'h07);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counts();
        t_cmd();
        t_irq();
        t_bus();
        t_misc();
        t_soft();
        t_hard();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule